// File: doc/BRIEF.md
# CPU/DMA Conflict Priority Arbiter

This block settles who owns a shared memory or peripheral resource in a cycle where both the processor and the DMA engine ask for it. Each cycle it looks at a processor request and a DMA request and drives at most one grant. A cycle with only one requester grants that requester at once. A cycle with both requesters is a conflict, and a two-bit priority field taken from the DMA global-control register decides who wins.

The field selects one of three policies. Processor-first always lets the processor win. DMA-first always lets the DMA win. Alternating gives the first conflict of an unbroken run to the processor and then switches the winner on each further back-to-back conflict. Any cycle without a conflict ends the run, so the next conflict starts again with the processor. The field is captured in a register, so a new value governs the cycle after it is written, and any change clears the run. A build parameter locks the arbiter to processor-first for the single-channel configuration, where the field is ignored.

The alternating policy uses a small state machine with three states. `ROT_IDLE` means no run is in progress. `ROT_DMA_TURN` means the processor won the last conflict, so the DMA wins the next one. `ROT_CPU_TURN` means the DMA won the last conflict, so the processor wins the next one. The transitions are as follows:
- A conflict in `ROT_IDLE` or `ROT_CPU_TURN` moves the machine to `ROT_DMA_TURN`.
- A conflict in `ROT_DMA_TURN` moves it to `ROT_CPU_TURN`.
- The machine returns to `ROT_IDLE` on a cycle without a conflict, on a change of the field, while the alternating policy is not in effect, and on reset.

Top module: `cpu_dma_arbiter`

## Requirements
- R1: When exactly one of `cpu_req`/`dma_req` is high (and reset is low), its grant is high in that same cycle, whatever the policy.
- R2: `cpu_gnt` and `dma_gnt` are never high together, and neither is high when its request is low.
- R3: With the policy field value in effect equal to 2'b00 or the reserved 2'b11, every conflict is granted to the processor.
- R4: With the value in effect equal to 2'b01, every conflict is granted to the DMA.
- R5: With the value in effect equal to 2'b10, a conflict that follows a cycle with no conflict is granted to the processor.
- R6: With 2'b10 in effect, conflicts in consecutive cycles alternate their winner, starting processor, DMA, processor, and so on.
- R7: Under 2'b10, a single cycle without a conflict ends the run, and the next conflict goes to the processor.
- R8: The value in effect in a cycle is the field value sampled at the previous clock edge. A changed value therefore applies one cycle later, and the change clears the alternation, so the first alternating conflict afterwards goes to the processor.
- R9: With parameter `CPU_ONLY` = 1, every conflict goes to the processor and the field has no effect.
- R10: While the synchronous active-high `rst` is high, both grants are low. The first conflict under 2'b10 after reset goes to the processor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one instruction cycle per period |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor requests the shared resource this cycle |
| dma_req | input | 1 | DMA requests the shared resource this cycle |
| pri_field | input | 2 | Priority policy: 00 processor, 01 DMA, 10 alternating, 11 reserved (processor) |
| cpu_gnt | output | 1 | Resource granted to the processor this cycle |
| dma_gnt | output | 1 | Resource granted to the DMA this cycle |

## Verification
Lone requests and idle cycles are applied under every policy to show that the field only matters in a conflict. Runs of back-to-back conflicts are applied under each policy to tell the fixed policies apart from the alternating one. Under the alternating policy, runs are broken by a single idle or single-request cycle to show that a run restarts with the processor instead of resuming the alternation. Field changes in the middle of a conflict run check the one-cycle delay and the clearing of the run. A second instance built with the lock parameter receives the same stimulus and must always favour the processor.

// File: rtl/cpu_dma_arb_pkg.sv
package cpu_dma_arb_pkg;

    localparam int PRI_W = 2;

    typedef enum logic [1:0] {
        MODE_CPU = 2'd0,
        MODE_DMA = 2'd1,
        MODE_ROT = 2'd2
    } arb_mode_e;

    typedef enum logic [1:0] {
        ROT_IDLE     = 2'd0,
        ROT_DMA_TURN = 2'd1,
        ROT_CPU_TURN = 2'd2
    } rot_state_e;

endpackage

// File: rtl/cpu_dma_arb_mode_dec.sv
module cpu_dma_arb_mode_dec
    import cpu_dma_arb_pkg::*;
#(
    parameter bit CPU_ONLY = 1'b0
) (
    input  logic             clk,
    input  logic [PRI_W-1:0] pri_field,
    output arb_mode_e        mode,
    output logic             pri_changed
);
    logic [PRI_W-1:0] pri_q;

    // Field capture: a written value governs the following cycle.
    always_ff @(posedge clk) begin
        pri_q <= pri_field;
    end

    generate
        if (CPU_ONLY) begin : g_locked
            assign mode        = MODE_CPU;
            assign pri_changed = 1'b0;
        end else begin : g_select
            always_comb begin
                unique case (pri_q)
                    2'b01:   mode = MODE_DMA;
                    2'b10:   mode = MODE_ROT;
                    default: mode = MODE_CPU;
                endcase
            end
            assign pri_changed = (pri_field != pri_q);
        end
    endgenerate
endmodule

// File: rtl/cpu_dma_arb_rot_fsm.sv
module cpu_dma_arb_rot_fsm
    import cpu_dma_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  arb_mode_e  mode,
    input  logic       conflict,
    input  logic       pri_changed,
    output rot_state_e state
);
    rot_state_e state_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ROT_IDLE;
        end else begin
            state <= state_n;
        end
    end

    always_comb begin
        state_n = ROT_IDLE;
        if (mode == MODE_ROT && conflict && !pri_changed) begin
            unique case (state)
                ROT_IDLE:     state_n = ROT_DMA_TURN;
                ROT_DMA_TURN: state_n = ROT_CPU_TURN;
                ROT_CPU_TURN: state_n = ROT_DMA_TURN;
                default:      state_n = ROT_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cpu_dma_arb_grant.sv
module cpu_dma_arb_grant
    import cpu_dma_arb_pkg::*;
(
    input  logic       rst,
    input  logic       cpu_req,
    input  logic       dma_req,
    input  arb_mode_e  mode,
    input  rot_state_e state,
    output logic       cpu_gnt,
    output logic       dma_gnt
);
    logic dma_wins;

    always_comb begin
        unique case (mode)
            MODE_DMA: dma_wins = 1'b1;
            MODE_ROT: dma_wins = (state == ROT_DMA_TURN);
            default:  dma_wins = 1'b0;
        endcase
    end

    always_comb begin
        cpu_gnt = 1'b0;
        dma_gnt = 1'b0;
        if (!rst) begin
            if (cpu_req && dma_req) begin
                cpu_gnt = !dma_wins;
                dma_gnt = dma_wins;
            end else begin
                cpu_gnt = cpu_req;
                dma_gnt = dma_req;
            end
        end
    end
endmodule

// File: rtl/cpu_dma_arbiter.sv
module cpu_dma_arbiter
    import cpu_dma_arb_pkg::*;
#(
    parameter bit CPU_ONLY = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cpu_req,
    input  logic       dma_req,
    input  logic [1:0] pri_field,
    output logic       cpu_gnt,
    output logic       dma_gnt
);
    arb_mode_e  mode;
    rot_state_e state;
    logic       pri_changed;
    logic       conflict;

    assign conflict = cpu_req & dma_req;

    cpu_dma_arb_mode_dec #(.CPU_ONLY(CPU_ONLY)) u_mode (
        .clk         (clk),
        .pri_field   (pri_field),
        .mode        (mode),
        .pri_changed (pri_changed)
    );

    cpu_dma_arb_rot_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .mode        (mode),
        .conflict    (conflict),
        .pri_changed (pri_changed),
        .state       (state)
    );

    cpu_dma_arb_grant u_gnt (
        .rst     (rst),
        .cpu_req (cpu_req),
        .dma_req (dma_req),
        .mode    (mode),
        .state   (state),
        .cpu_gnt (cpu_gnt),
        .dma_gnt (dma_gnt)
    );
endmodule

// File: rtl/cpu_dma_arbiter_chk.sv
module cpu_dma_arbiter_chk #(
    parameter bit CPU_ONLY = 1'b0
) (
    input logic       clk,
    input logic       rst,
    input logic       cpu_req,
    input logic       dma_req,
    input logic [1:0] pri_field,
    input logic       cpu_gnt,
    input logic       dma_gnt
);
    assert_one_hot_R2: assert property (@(posedge clk) disable iff (rst)
        !(cpu_gnt && dma_gnt));

    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
        (cpu_gnt |-> cpu_req) and (dma_gnt |-> dma_req));

    assert_lone_request_R1: assert property (@(posedge clk) disable iff (rst)
        (cpu_req != dma_req) |-> (cpu_gnt == cpu_req && dma_gnt == dma_req));

    assert_cpu_policy_R3: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && dma_req && !$past(rst) &&
         (CPU_ONLY || $past(pri_field) == 2'b00 || $past(pri_field) == 2'b11))
        |-> cpu_gnt);

    assert_dma_policy_R4: assert property (@(posedge clk) disable iff (rst)
        (!CPU_ONLY && cpu_req && dma_req && !$past(rst) && $past(pri_field) == 2'b01)
        |-> dma_gnt);

    assert_run_start_R5: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && dma_req && !$past(rst) && !$past(cpu_req && dma_req)
         && $past(pri_field) == 2'b10) |-> cpu_gnt);

    assert_reset_quiet_R10: assert property (@(posedge clk)
        rst |-> !(cpu_gnt || dma_gnt));
endmodule

bind cpu_dma_arbiter cpu_dma_arbiter_chk #(.CPU_ONLY(CPU_ONLY)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_req   (cpu_req),
    .dma_req   (dma_req),
    .pri_field (pri_field),
    .cpu_gnt   (cpu_gnt),
    .dma_gnt   (dma_gnt)
);

// File: tb/cpu_dma_arbiter_tb_top.sv
module cpu_dma_arbiter_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  MAX_CYCLES = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_req = 1'b0;
    logic       dma_req = 1'b0;
    logic [1:0] pri_field = 2'b00;
    logic       cpu_gnt, dma_gnt, lk_cpu_gnt, lk_dma_gnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_dma_arbiter #(.CPU_ONLY(1'b0)) dut_i (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .dma_req(dma_req),
        .pri_field(pri_field), .cpu_gnt(cpu_gnt), .dma_gnt(dma_gnt));

    cpu_dma_arbiter #(.CPU_ONLY(1'b1)) dut_lock_i (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .dma_req(dma_req),
        .pri_field(pri_field), .cpu_gnt(lk_cpu_gnt), .dma_gnt(lk_dma_gnt));

    typedef struct {
        logic  cpu, dma, lk_cpu, lk_dma;
        string tag;
    } exp_t;

    exp_t queue_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    // Reference state, kept from the requirements alone.
    logic [1:0] m_pri  = 2'b00;
    bit         m_turn = 1'b0; // 1: DMA wins the next alternating conflict

    task automatic drive(input logic r, input logic c, input logic d,
                         input logic [1:0] p, input string tag);
        exp_t e;
        bit   conf;
        bit   dwin;
        @(negedge clk);
        rst = r; cpu_req = c; dma_req = d; pri_field = p;
        conf = c && d;
        unique case (m_pri)
            2'b01:   dwin = 1'b1;
            2'b10:   dwin = m_turn;
            default: dwin = 1'b0;
        endcase
        e.tag = tag;
        if (r) begin
            e.cpu = 0; e.dma = 0; e.lk_cpu = 0; e.lk_dma = 0;
        end else if (conf) begin
            e.cpu = !dwin; e.dma = dwin; e.lk_cpu = 1; e.lk_dma = 0;
        end else begin
            e.cpu = c; e.dma = d; e.lk_cpu = c; e.lk_dma = d;
        end
        queue_q.push_back(e);
        if (r || !conf || p != m_pri || m_pri != 2'b10) m_turn = 1'b0;
        else m_turn = !m_turn;
        m_pri = p;
    endtask

    // Monitor: compares each expected item a quarter period after the drive.
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            while (queue_q.size() > 0) begin
                exp_t e;
                e = queue_q.pop_front();
                checks++;
                if (cpu_gnt !== e.cpu || dma_gnt !== e.dma) begin
                    errors++;
                    $display("FAIL %s: gnt cpu/dma=%b%b expected %b%b",
                             e.tag, cpu_gnt, dma_gnt, e.cpu, e.dma);
                end
                checks++;
                if (lk_cpu_gnt !== e.lk_cpu || lk_dma_gnt !== e.lk_dma) begin
                    errors++;
                    $display("FAIL R9 (%s): locked gnt cpu/dma=%b%b expected %b%b",
                             e.tag, lk_cpu_gnt, lk_dma_gnt, e.lk_cpu, e.lk_dma);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * MAX_CYCLES);
        errors++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R10: grants low in reset even with requests present
        drive(1, 1, 1, 2'b10, "R10");
        drive(1, 1, 0, 2'b10, "R10");
        // R10 then R5/R6: first alternating conflict after reset goes to CPU
        drive(0, 1, 1, 2'b10, "R10");
        drive(0, 1, 1, 2'b10, "R6");
        drive(0, 1, 1, 2'b10, "R6");
        drive(0, 1, 1, 2'b10, "R6");
        // R7: a lone-request cycle breaks the run
        drive(0, 0, 1, 2'b10, "R1");
        drive(0, 1, 1, 2'b10, "R7");
        drive(0, 1, 1, 2'b10, "R6");
        drive(0, 0, 0, 2'b10, "R2");
        drive(0, 1, 1, 2'b10, "R7");
        drive(0, 1, 1, 2'b10, "R6");
        // R8: switch to CPU policy mid-run; old policy holds one cycle
        drive(0, 1, 1, 2'b00, "R8");
        drive(0, 1, 1, 2'b00, "R3");
        drive(0, 1, 1, 2'b00, "R3");
        drive(0, 1, 0, 2'b00, "R1");
        drive(0, 0, 1, 2'b00, "R1");
        drive(0, 0, 0, 2'b00, "R2");
        // R4: DMA policy
        drive(0, 1, 1, 2'b01, "R8");
        drive(0, 1, 1, 2'b01, "R4");
        drive(0, 1, 1, 2'b01, "R4");
        drive(0, 1, 0, 2'b01, "R1");
        drive(0, 1, 1, 2'b01, "R4");
        // R3: reserved value acts as CPU policy
        drive(0, 1, 1, 2'b11, "R8");
        drive(0, 1, 1, 2'b11, "R3");
        drive(0, 1, 1, 2'b11, "R3");
        // R8: change into alternating during a run; run restarts at CPU
        drive(0, 1, 1, 2'b10, "R8");
        drive(0, 1, 1, 2'b10, "R8");
        drive(0, 1, 1, 2'b10, "R6");
        drive(0, 1, 1, 2'b10, "R6");
        // R8: field toggled away and back within a run clears it
        drive(0, 1, 1, 2'b01, "R8");
        drive(0, 1, 1, 2'b10, "R8");
        drive(0, 1, 1, 2'b10, "R8");
        drive(0, 1, 1, 2'b10, "R6");
        // R10: reset in the middle of a run
        drive(1, 1, 1, 2'b10, "R10");
        drive(0, 1, 1, 2'b10, "R10");
        drive(0, 1, 1, 2'b10, "R6");
        drive(0, 0, 0, 2'b10, "R2");
        @(negedge clk);
        @(negedge clk);
        #(CLK_PERIOD/2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule